// File: doc/BRIEF.md
# Register-and-Stack Execution Core

This block runs one already-decoded instruction per clock. It holds a file of general-purpose registers, a last-in first-out hardware stack, a program counter and three status flags: overflow, zero and negative. An upstream fetch/decode stage presents one instruction with a valid strobe. The instruction carries an opcode, a source select (register or immediate), two register indices, a 16-bit immediate and a branch target. The whole architectural state is visible on the outputs after every step, so a controller or a test harness can follow execution directly.

Two-operand operations write their result into the second operand (`rb`). A compare evaluates `rb - src`, so a source larger than the destination register sets the negative flag. Stack misuse is reported as a fault. A pop with no entries and a push into a full stack each leave the stack and the registers untouched and raise a one-cycle error pulse.

Opcode encoding on `in_op`: 0 move, 1 add, 2 push, 3 pop, 4 compare, 5 jump, 6 jump-if-equal, 7 no operation (the PC advances). The source operand is `in_imm` when `in_src_imm` is 1 and register `in_ra` otherwise. The flag order used in this brief is {OV, Z, N}.

Top module: `stkc_core`

## Requirements
- R1: A synchronous active-low reset clears every register, all three flags, the stack depth, the PC and both error outputs to 0.
- R2: Move (op 0) writes the source operand (immediate or register `ra`) into register `rb` and leaves all flags unchanged.
- R3: Add (op 1) writes source + `rb` (mod 2^16) into `rb` and leaves `ra` unchanged. Z is set when the sum is 0, N is set to sum bit 15, and OV is set on two's-complement signed overflow.
- R4: Push (op 2) on a stack that is not full places the source operand on top and raises the depth by one.
- R5: Pop (op 3) on a non-empty stack moves the top entry into `rb` and lowers the depth by one, so values come back in last-in, first-out order.
- R6: Pop on an empty stack leaves every register and the depth unchanged, and pulses `err_underflow`.
- R7: Push on a stack that holds DEPTH entries leaves the stack unchanged and pulses `err_overflow`.
- R8: Compare (op 4) computes `rb - src`. It sets Z when the difference is 0, sets N to difference bit 15 and sets OV on signed overflow. It writes no register.
- R9: Jump (op 5) loads the PC with `in_target`.
- R10: Jump-if-equal (op 6) loads the PC with `in_target` when Z is set, and otherwise advances the PC by one.
- R11: Every other accepted instruction, including a faulting push or pop, advances the PC by one. A cycle without `in_valid` changes no state.
- R12: Each error output is high for exactly the one cycle that follows the offending instruction, and is low after a valid-free cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Instruction present this cycle |
| in_op | input | 3 | Opcode |
| in_src_imm | input | 1 | 1: source is the immediate; 0: source is register `ra` |
| in_ra | input | 3 | Source register index |
| in_rb | input | 3 | Second operand / destination register index |
| in_imm | input | 16 | Immediate value |
| in_target | input | 8 | Branch target address |
| regs_flat | output | 128 | Register i on bits [16*i+15 : 16*i] |
| flag_ov | output | 1 | Signed-overflow flag |
| flag_z | output | 1 | Zero flag |
| flag_n | output | 1 | Negative flag |
| pc | output | 8 | Address of the next instruction |
| stack_depth | output | 5 | Number of entries on the stack |
| err_underflow | output | 1 | One-cycle pulse after a pop on an empty stack |
| err_overflow | output | 1 | One-cycle pulse after a push onto a full stack |

## Verification
The compare is tried with equal operands, with the source larger and with the source smaller. These three cases separate the Z-only, N-only and no-flag outcomes, which exposes a reversed subtraction. The add is run on small values, on 0x7FFF + 1 and on 0x8000 + 0x8000, which separates the N, OV and Z updates from one another. Jump-if-equal is run once after an equal compare and once after an unequal one. The stack is pushed to its capacity and then drained, so the order of the values exposes any index slip. Pops on an empty stack and pushes onto a full one must leave both the destination register and the depth unchanged.

// File: rtl/stkc_pkg.sv
// Shared definitions for the execution core: opcode encoding and sizes.
// Assumes the decoder upstream emits these exact 3-bit codes.
package stkc_pkg;
    typedef enum logic [2:0] {
        OP_MOV = 3'd0,
        OP_ADD = 3'd1,
        OP_PSH = 3'd2,
        OP_POP = 3'd3,
        OP_CMP = 3'd4,
        OP_JMP = 3'd5,
        OP_JEQ = 3'd6,
        OP_NOP = 3'd7
    } op_e;
endpackage

// File: rtl/stkc_regfile.sv
// Register file: NREG registers of W bits, one write port, all contents
// exposed flat. Assumes the write index is in range when we is high.
module stkc_regfile #(
    parameter int NREG = 8,
    parameter int W    = 16,
    localparam int AW  = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [W-1:0]      wdata,
    output logic [NREG*W-1:0] rd_flat
);
    for (genvar g = 0; g < NREG; g++) begin : g_reg
        logic [W-1:0] q;
        // Hold or update one register.
        always_ff @(posedge clk) begin
            if (!rst_n)
                q <= '0;
            else if (we && waddr == AW'(g))
                q <= wdata;
        end
        assign rd_flat[g*W +: W] = q;
    end
endmodule

// File: rtl/stkc_stack.sv
// LIFO stack with DEPTH entries. A push when full and a pop when empty are
// ignored; the full/empty outputs let the caller flag them as faults.
module stkc_stack #(
    parameter int DEPTH = 16,
    parameter int W     = 16,
    localparam int DW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic          pop,
    input  logic [W-1:0]  din,
    output logic [W-1:0]  top,
    output logic [DW-1:0] depth,
    output logic          full,
    output logic          empty
);
    logic [W-1:0] mem [DEPTH];

    assign full  = (depth == DW'(DEPTH));
    assign empty = (depth == '0);

    // Track the fill level; faulting requests leave it alone.
    always_ff @(posedge clk) begin
        if (!rst_n)
            depth <= '0;
        else if (push && !full)
            depth <= depth + 1'b1;
        else if (pop && !empty)
            depth <= depth - 1'b1;
    end

    // Write a pushed value into the first free slot.
    always_ff @(posedge clk) begin
        if (push && !full)
            mem[depth[DW-2:0]] <= din;
    end

    // Present the newest entry (don't-care when empty).
    always_comb begin
        top = '0;
        if (!empty)
            top = mem[DW'(depth - 1'b1)];
    end

    assert_underflow_keeps_depth_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push && empty) |=> (depth == '0));
    assert_full_push_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full) |=> (depth == DW'(DEPTH)));
    assert_depth_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        depth <= DW'(DEPTH));
    assert_push_grows_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !full) |=> (depth == $past(depth) + 1'b1));
endmodule

// File: rtl/stkc_alu.sv
// Add / reverse-subtract unit with zero, negative and signed-overflow
// outputs. sub=1 computes b - a; sub=0 computes a + b. Purely combinational.
module stkc_alu #(
    parameter int W = 16
) (
    input  logic         sub,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] res,
    output logic         z,
    output logic         n,
    output logic         ov
);
    // Produce the result and its flags.
    always_comb begin
        if (sub) begin
            res = b - a;
            ov  = (b[W-1] != a[W-1]) && (res[W-1] != b[W-1]);
        end else begin
            res = a + b;
            ov  = (a[W-1] == b[W-1]) && (res[W-1] != a[W-1]);
        end
        z = (res == '0);
        n = res[W-1];
    end
endmodule

// File: rtl/stkc_core.sv
// Top of the execution core. Accepts one decoded instruction per valid
// cycle, updates registers, stack, flags and PC, and pulses an error output
// for one cycle on stack underflow or overflow. Assumes in_* are stable
// around the clock edge while in_valid is high.
module stkc_core
    import stkc_pkg::*;
#(
    parameter int NREG  = 8,
    parameter int W     = 16,
    parameter int DEPTH = 16,
    parameter int PCW   = 8,
    localparam int AW   = $clog2(NREG),
    localparam int DW   = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [2:0]        in_op,
    input  logic              in_src_imm,
    input  logic [AW-1:0]     in_ra,
    input  logic [AW-1:0]     in_rb,
    input  logic [W-1:0]      in_imm,
    input  logic [PCW-1:0]    in_target,
    output logic [NREG*W-1:0] regs_flat,
    output logic              flag_ov,
    output logic              flag_z,
    output logic              flag_n,
    output logic [PCW-1:0]    pc,
    output logic [DW-1:0]     stack_depth,
    output logic              err_underflow,
    output logic              err_overflow
);
    op_e          op;
    logic [W-1:0] reg_a, reg_b, src, alu_res, stk_top;
    logic         alu_z, alu_n, alu_ov;
    logic         stk_full, stk_empty;
    logic         do_push, do_pop, rf_we;
    logic [W-1:0] rf_wdata;

    assign op    = op_e'(in_op);
    assign reg_a = regs_flat[in_ra*W +: W];
    assign reg_b = regs_flat[in_rb*W +: W];
    assign src   = in_src_imm ? in_imm : reg_a;

    assign do_push = in_valid && (op == OP_PSH);
    assign do_pop  = in_valid && (op == OP_POP);

    // Select what, if anything, is written to the destination register.
    always_comb begin
        rf_we    = 1'b0;
        rf_wdata = src;
        if (in_valid) begin
            case (op)
                OP_MOV: rf_we = 1'b1;
                OP_ADD: begin rf_we = 1'b1; rf_wdata = alu_res; end
                OP_POP: begin rf_we = !stk_empty; rf_wdata = stk_top; end
                default: rf_we = 1'b0;
            endcase
        end
    end

    stkc_regfile #(.NREG(NREG), .W(W)) u_rf (
        .clk(clk), .rst_n(rst_n), .we(rf_we), .waddr(in_rb),
        .wdata(rf_wdata), .rd_flat(regs_flat)
    );

    stkc_stack #(.DEPTH(DEPTH), .W(W)) u_stk (
        .clk(clk), .rst_n(rst_n), .push(do_push), .pop(do_pop), .din(src),
        .top(stk_top), .depth(stack_depth), .full(stk_full), .empty(stk_empty)
    );

    stkc_alu #(.W(W)) u_alu (
        .sub(op == OP_CMP), .a(src), .b(reg_b), .res(alu_res),
        .z(alu_z), .n(alu_n), .ov(alu_ov)
    );

    // Latch the flags after add and compare only.
    always_ff @(posedge clk) begin
        if (!rst_n)
            {flag_ov, flag_z, flag_n} <= 3'b000;
        else if (in_valid && (op == OP_ADD || op == OP_CMP))
            {flag_ov, flag_z, flag_n} <= {alu_ov, alu_z, alu_n};
    end

    // Advance or redirect the program counter.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pc <= '0;
        else if (in_valid) begin
            if (op == OP_JMP || (op == OP_JEQ && flag_z))
                pc <= in_target;
            else
                pc <= pc + 1'b1;
        end
    end

    // Raise a one-cycle fault pulse for stack misuse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_underflow <= 1'b0;
            err_overflow  <= 1'b0;
        end else begin
            err_underflow <= do_pop && stk_empty;
            err_overflow  <= do_push && stk_full;
        end
    end

    logic [W-1:0] regs_arr [NREG];
    for (genvar g = 0; g < NREG; g++) begin : g_view
        assign regs_arr[g] = regs_flat[g*W +: W];
    end

    assert_mov_keeps_flags_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == OP_MOV) |=> $stable({flag_ov, flag_z, flag_n}));
    assert_add_result_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == OP_ADD && !in_src_imm && in_ra != in_rb) |=>
        (regs_arr[$past(in_rb)] == W'($past(regs_arr[in_ra]) + $past(regs_arr[in_rb]))));
    assert_cmp_keeps_reg_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == OP_CMP) |=> $stable(regs_flat));
    assert_jmp_target_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == OP_JMP) |=> (pc == $past(in_target)));
    assert_jeq_not_taken_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == OP_JEQ && !flag_z) |=> (pc == $past(pc) + 1'b1));
    assert_idle_holds_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(pc) && $stable(regs_flat) && $stable(stack_depth)));
    assert_underflow_cause_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_underflow) |-> $past(do_pop && stk_empty));
    assert_underflow_keeps_reg_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (do_pop && stk_empty) |=> $stable(regs_flat));
endmodule

// File: tb/test_stkc_core.sv
// Self-checking bench: a vector table of instructions with expected state,
// then directed tests for stack faults, idle cycles and reset.
module test_stkc_core;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 21;

    typedef struct packed {
        logic [2:0]  op;
        logic        imm;
        logic [2:0]  ra;
        logic [2:0]  rb;
        logic [15:0] val;
        logic [7:0]  tgt;
        logic [2:0]  chk;
        logic [15:0] exp;
        logic [2:0]  flg;   // {OV, Z, N}
        logic [7:0]  epc;
        logic [4:0]  dep;
    } vec_t;

    localparam vec_t VEC [NVEC] = '{
        '{3'd0, 1'b1, 3'd0, 3'd0, 16'd5,      8'd0,  3'd0, 16'd5,      3'b000, 8'd1,  5'd0}, // R2 MOV #5,R0
        '{3'd0, 1'b1, 3'd0, 3'd1, 16'd7,      8'd0,  3'd1, 16'd7,      3'b000, 8'd2,  5'd0}, // R2
        '{3'd1, 1'b0, 3'd0, 3'd1, 16'd0,      8'd0,  3'd1, 16'd12,     3'b000, 8'd3,  5'd0}, // R3 ADD R0,R1
        '{3'd2, 1'b0, 3'd1, 3'd0, 16'd0,      8'd0,  3'd0, 16'd5,      3'b000, 8'd4,  5'd1}, // R4 PSH R1
        '{3'd2, 1'b1, 3'd0, 3'd0, 16'd2,      8'd0,  3'd1, 16'd12,     3'b000, 8'd5,  5'd2}, // R4 PSH #2
        '{3'd5, 1'b0, 3'd0, 3'd0, 16'd0,      8'd0,  3'd0, 16'd5,      3'b000, 8'd0,  5'd2}, // R9 JMP 0
        '{3'd3, 1'b0, 3'd0, 3'd2, 16'd0,      8'd0,  3'd2, 16'd2,      3'b000, 8'd1,  5'd1}, // R5 POP R2
        '{3'd3, 1'b0, 3'd0, 3'd3, 16'd0,      8'd0,  3'd3, 16'd12,     3'b000, 8'd2,  5'd0}, // R5 POP R3
        '{3'd0, 1'b1, 3'd0, 3'd4, 16'd9,      8'd0,  3'd4, 16'd9,      3'b000, 8'd3,  5'd0},
        '{3'd0, 1'b1, 3'd0, 3'd5, 16'd9,      8'd0,  3'd5, 16'd9,      3'b000, 8'd4,  5'd0},
        '{3'd4, 1'b0, 3'd4, 3'd5, 16'd0,      8'd0,  3'd5, 16'd9,      3'b010, 8'd5,  5'd0}, // R8 equal
        '{3'd6, 1'b0, 3'd0, 3'd0, 16'd0,      8'd20, 3'd4, 16'd9,      3'b010, 8'd20, 5'd0}, // R10 taken
        '{3'd0, 1'b1, 3'd0, 3'd4, 16'd10,     8'd0,  3'd4, 16'd10,     3'b010, 8'd21, 5'd0}, // R2 flags kept
        '{3'd4, 1'b0, 3'd4, 3'd5, 16'd0,      8'd0,  3'd4, 16'd10,     3'b001, 8'd22, 5'd0}, // R8 src larger
        '{3'd6, 1'b0, 3'd0, 3'd0, 16'd0,      8'd3,  3'd5, 16'd9,      3'b001, 8'd23, 5'd0}, // R10 not taken
        '{3'd0, 1'b1, 3'd0, 3'd4, 16'd3,      8'd0,  3'd4, 16'd3,      3'b001, 8'd24, 5'd0},
        '{3'd4, 1'b0, 3'd4, 3'd5, 16'd0,      8'd0,  3'd5, 16'd9,      3'b000, 8'd25, 5'd0}, // R8 src smaller
        '{3'd0, 1'b1, 3'd0, 3'd6, 16'h7FFF,   8'd0,  3'd6, 16'h7FFF,   3'b000, 8'd26, 5'd0},
        '{3'd1, 1'b1, 3'd0, 3'd6, 16'd1,      8'd0,  3'd6, 16'h8000,   3'b101, 8'd27, 5'd0}, // R3 OV,N
        '{3'd0, 1'b0, 3'd6, 3'd7, 16'd0,      8'd0,  3'd7, 16'h8000,   3'b101, 8'd28, 5'd0}, // R2 reg source
        '{3'd1, 1'b0, 3'd7, 3'd6, 16'd0,      8'd0,  3'd6, 16'd0,      3'b110, 8'd29, 5'd0}  // R3 OV,Z
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [2:0]   in_op = '0;
    logic         in_src_imm = 1'b0;
    logic [2:0]   in_ra = '0;
    logic [2:0]   in_rb = '0;
    logic [15:0]  in_imm = '0;
    logic [7:0]   in_target = '0;
    logic [127:0] regs_flat;
    logic         flag_ov, flag_z, flag_n;
    logic [7:0]   pc;
    logic [4:0]   stack_depth;
    logic         err_underflow, err_overflow;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    stkc_core i_stkc_core (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
        .in_src_imm(in_src_imm), .in_ra(in_ra), .in_rb(in_rb), .in_imm(in_imm),
        .in_target(in_target), .regs_flat(regs_flat), .flag_ov(flag_ov),
        .flag_z(flag_z), .flag_n(flag_n), .pc(pc), .stack_depth(stack_depth),
        .err_underflow(err_underflow), .err_overflow(err_overflow)
    );

    task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] rget(input int idx);
        return regs_flat[idx*16 +: 16];
    endfunction

    // Drive one instruction (or idle when v=0) for one edge; return at negedge.
    task automatic step(input logic v, input logic [2:0] op, input logic imm,
                        input logic [2:0] ra, input logic [2:0] rb,
                        input logic [15:0] val, input logic [7:0] tgt);
        in_valid = v; in_op = op; in_src_imm = imm;
        in_ra = ra; in_rb = rb; in_imm = val; in_target = tgt;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        check("R1 regs", regs_flat, '0);
        check("R1 flags", {flag_ov, flag_z, flag_n}, 3'b000);
        check("R1 pc", pc, 8'd0);
        check("R1 depth", stack_depth, 5'd0);
        check("R1 errors", {err_underflow, err_overflow}, 2'b00);

        for (int i = 0; i < NVEC; i++) begin
            step(1'b1, VEC[i].op, VEC[i].imm, VEC[i].ra, VEC[i].rb, VEC[i].val, VEC[i].tgt);
            check($sformatf("R2-R10 vec%0d reg", i), rget(int'(VEC[i].chk)), VEC[i].exp);
            check($sformatf("R3/R8 vec%0d flags", i), {flag_ov, flag_z, flag_n}, VEC[i].flg);
            check($sformatf("R9/R10/R11 vec%0d pc", i), pc, VEC[i].epc);
            check($sformatf("R4/R5 vec%0d depth", i), stack_depth, VEC[i].dep);
        end
        check("R3 ra unchanged", rget(7), 16'h8000);

        // R11: idle cycle changes nothing
        step(1'b0, 3'd5, 1'b0, 3'd0, 3'd0, 16'd0, 8'd77);
        check("R11 idle pc", pc, 8'd29);
        check("R11 idle flags", {flag_ov, flag_z, flag_n}, 3'b110);

        // R6: pop on empty stack
        step(1'b1, 3'd3, 1'b0, 3'd0, 3'd3, 16'd0, 8'd0);
        check("R6 underflow pulse", err_underflow, 1'b1);
        check("R6 reg kept", rget(3), 16'd12);
        check("R6 depth kept", stack_depth, 5'd0);
        check("R11 pc after fault", pc, 8'd30);
        step(1'b0, 3'd0, 1'b0, 3'd0, 3'd0, 16'd0, 8'd0);
        check("R12 underflow clears", err_underflow, 1'b0);

        // R7: fill then overflow
        for (int i = 0; i < 16; i++)
            step(1'b1, 3'd2, 1'b1, 3'd0, 3'd0, 16'(100 + i), 8'd0);
        check("R4 depth full", stack_depth, 5'd16);
        check("R7 no early overflow", err_overflow, 1'b0);
        step(1'b1, 3'd2, 1'b1, 3'd0, 3'd0, 16'd999, 8'd0);
        check("R7 overflow pulse", err_overflow, 1'b1);
        check("R7 depth kept", stack_depth, 5'd16);
        step(1'b0, 3'd0, 1'b0, 3'd0, 3'd0, 16'd0, 8'd0);
        check("R12 overflow clears", err_overflow, 1'b0);

        // R5: drain in LIFO order; the rejected 999 must not appear
        for (int i = 0; i < 16; i++) begin
            step(1'b1, 3'd3, 1'b0, 3'd0, 3'd2, 16'd0, 8'd0);
            check($sformatf("R5 pop %0d", i), rget(2), 16'(115 - i));
        end
        check("R5 drained", stack_depth, 5'd0);

        // R1: reset in mid-run
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        check("R1 regs after reset", regs_flat, '0);
        check("R1 pc after reset", pc, 8'd0);
        check("R1 flags after reset", {flag_ov, flag_z, flag_n}, 3'b000);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog: count a hang as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule